// File: doc/BRIEF.md
# Reset Source Combiner with Power-On Status Flag

This block merges two reset causes into one synchronous system reset. The first is an active-low external reset pin. The second is an on-chip power-on event. The pin level is first brought into the clock domain by a short synchroniser chain. It then passes through a low-level qualifier, which accepts a reset request only when the low level lasts long enough. Shorter dips are treated as noise. A configuration input can strip the pin of its reset role. In that case the pin acts as a plain digital input, and its synchronised level is presented on a separate output.

After a power-on event the system reset stays asserted while an "operating conditions met" input is low. Once every cause has gone quiet, the reset is released on a clock edge after a parameterised number of consecutive quiet cycles.

The block also holds a software-visible power-on status flag. Only a power-on event clears it to 0. Only a register write changes it otherwise. Pin-driven resets and reset release leave it as it is, so software can tell a fresh power-up from other resets.

Top module: `rst_combiner`

## Requirements
- R1: With `pin_rst_en`=1, a pin held low for at least `LOW_CYC` consecutive synchronised samples asserts `sys_rst`, and `sys_rst` stays asserted while the pin remains low.
- R2: A low pulse shorter than `LOW_CYC` synchronised samples causes no reset. Any high sample restarts the low count from zero, so two short pulses separated by a high sample never add up.
- R3: The pin is input-only. The system reset never acts on the pin path: while `sys_rst` is held, the pin level still reaches `pin_gpio` when the reset function is disabled.
- R4: With `pin_rst_en`=0, the pin never causes a reset, and `pin_gpio` shows the pin level `SYNC_STAGES` clock edges after it changes. With `pin_rst_en`=1, `pin_gpio` reads 0.
- R5: `por_evt` high at a clock edge clears `por_flag` to 0 after that edge. This takes priority over a simultaneous flag write.
- R6: `por_flag` keeps its value across pin-driven resets and across reset release. Without `por_evt` or a write, it never changes.
- R7: A write (`flag_wr_en`=1) with `flag_wr_data`=1 sets `por_flag` to 1 after the edge. No other event sets it.
- R8: After a power-on event, `sys_rst` stays asserted for as long as `cond_ok` is low.
- R9: `sys_rst` asserts after the first edge at which any cause is active. It deasserts after the `REL_CYC`-th consecutive edge with no active cause, always on a clock edge.
- R10: A write with `flag_wr_data`=0 clears `por_flag` to 0 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| pin_n_raw | input | 1 | Raw external reset pin level, active low, asynchronous |
| pin_rst_en | input | 1 | 1: pin acts as reset; 0: pin is a digital input |
| por_evt | input | 1 | Power-on event, active high, sampled on the clock |
| cond_ok | input | 1 | Operating conditions met |
| flag_wr_en | input | 1 | Write strobe for the status flag |
| flag_wr_data | input | 1 | Value written to the status flag |
| sys_rst | output | 1 | Synchronous system reset, active high |
| por_flag | output | 1 | Power-on status flag, 0 after a power-on |
| pin_gpio | output | 1 | Synchronised pin level when reset function is off, else 0 |

## Verification
The flag changes one edge after a write or power-on event. A pin level reaches `pin_gpio` two edges after it changes. A qualified pin reset shows on `sys_rst` after the synchroniser delay plus `LOW_CYC` counting edges plus one register edge. Release comes on exactly the sixteenth quiet edge.

The bench drives inputs just after the falling edge. A behavioural model advances on each rising edge, and every output is compared at the following falling edge. Directed checks count rising edges explicitly from the stimulus: for example, they confirm that `sys_rst` is still high after 15 quiet edges and low after 16.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  // bits needed to hold the values 0..limit
  function automatic int unsigned cnt_bits(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

  // saturating increment used by the qualifier
  function automatic int unsigned sat_step(input int unsigned cur, input int unsigned lim);
    return (cur >= lim) ? lim : cur + 1;
  endfunction

  // count value on which the release counter lets go
  function automatic int unsigned last_quiet(input int unsigned cycles);
    return (cycles == 0) ? 0 : cycles - 1;
  endfunction
endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic init,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (init) sh <= '1;
        else      sh <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (init) sh <= '1;
        else      sh <= {sh[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/rstc_lowfilt.sv
module rstc_lowfilt #(
  parameter int unsigned LOW_CYC = 8
) (
  input  logic clk,
  input  logic init,
  input  logic en,
  input  logic lvl,
  output logic hold
);
  localparam int unsigned CW = rstc_pkg::cnt_bits(LOW_CYC);
  localparam logic [CW-1:0] FULL = CW'(LOW_CYC);

  logic [CW-1:0] run;

  // any high sample or disabled pin restarts the low count
  always_ff @(posedge clk) begin
    if (init || !en || lvl) run <= '0;
    else                    run <= CW'(rstc_pkg::sat_step(32'(run), LOW_CYC));
  end

  assign hold = en && (run == FULL);
endmodule

// File: rtl/rstc_release.sv
module rstc_release #(
  parameter int unsigned REL_CYC = 16
) (
  input  logic clk,
  input  logic por_evt,
  input  logic cond_ok,
  input  logic pin_hold,
  output logic sys_rst,
  output logic por_wait,
  output logic rst_cause
);
  localparam int unsigned RW = rstc_pkg::cnt_bits(REL_CYC);
  localparam logic [RW-1:0] LAST = RW'(rstc_pkg::last_quiet(REL_CYC));

  logic          wait_q;
  logic [RW-1:0] quiet;
  logic          rst_q;

  // power-on waits for conditions; the edge that sees cond_ok is already quiet
  always_ff @(posedge clk) begin
    if (por_evt)      wait_q <= 1'b1;
    else if (cond_ok) wait_q <= 1'b0;
  end

  assign rst_cause = por_evt | (wait_q & ~cond_ok) | pin_hold;

  always_ff @(posedge clk) begin
    if (rst_cause) begin
      quiet <= '0;
      rst_q <= 1'b1;
    end else if (rst_q) begin
      if (quiet == LAST) rst_q <= 1'b0;
      else               quiet <= quiet + 1'b1;
    end
  end

  assign sys_rst  = rst_q;
  assign por_wait = wait_q;
endmodule

// File: rtl/rstc_status.sv
module rstc_status (
  input  logic clk,
  input  logic por_evt,
  input  logic wr_en,
  input  logic wr_data,
  output logic flag
);
  // power-on clears with priority; only software writes otherwise
  always_ff @(posedge clk) begin
    if (por_evt)    flag <= 1'b0;
    else if (wr_en) flag <= wr_data;
  end
endmodule

// File: rtl/rst_combiner.sv
module rst_combiner #(
  parameter int unsigned LOW_CYC     = 8,
  parameter int unsigned REL_CYC     = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic pin_n_raw,
  input  logic pin_rst_en,
  input  logic por_evt,
  input  logic cond_ok,
  input  logic flag_wr_en,
  input  logic flag_wr_data,
  output logic sys_rst,
  output logic por_flag,
  output logic pin_gpio
);
  logic pin_sync;
  logic pin_hold;
  logic por_wait;
  logic rst_cause;

  rstc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .init(por_evt),
    .d   (pin_n_raw),
    .q   (pin_sync)
  );

  rstc_lowfilt #(.LOW_CYC(LOW_CYC)) u_filt (
    .clk (clk),
    .init(por_evt),
    .en  (pin_rst_en),
    .lvl (pin_sync),
    .hold(pin_hold)
  );

  rstc_release #(.REL_CYC(REL_CYC)) u_rel (
    .clk      (clk),
    .por_evt  (por_evt),
    .cond_ok  (cond_ok),
    .pin_hold (pin_hold),
    .sys_rst  (sys_rst),
    .por_wait (por_wait),
    .rst_cause(rst_cause)
  );

  rstc_status u_stat (
    .clk    (clk),
    .por_evt(por_evt),
    .wr_en  (flag_wr_en),
    .wr_data(flag_wr_data),
    .flag   (por_flag)
  );

  // pin only ever read; shown as data when its reset role is off
  assign pin_gpio = pin_rst_en ? 1'b0 : pin_sync;
endmodule

// File: rtl/rst_combiner_chk.sv
module rst_combiner_chk (
  input logic clk,
  input logic por_evt,
  input logic cond_ok,
  input logic pin_rst_en,
  input logic flag_wr_en,
  input logic flag_wr_data,
  input logic pin_sync,
  input logic pin_hold,
  input logic por_wait,
  input logic rst_cause,
  input logic sys_rst,
  input logic por_flag
);
  logic armed = 1'b0;
  logic seen  = 1'b0;
  always_ff @(posedge clk) begin
    if (por_evt) seen <= 1'b1;
    armed <= seen;
  end

  AST_FLAG_CLR_ON_POR: assert property (@(posedge clk) disable iff (!armed)
    por_evt |=> !por_flag); // R5
  AST_FLAG_KEEPS: assert property (@(posedge clk) disable iff (!armed)
    (!por_evt && !flag_wr_en) |=> $stable(por_flag)); // R6
  AST_FLAG_WRITE: assert property (@(posedge clk) disable iff (!armed)
    (!por_evt && flag_wr_en) |=> (por_flag == $past(flag_wr_data))); // R7
  AST_WAIT_HOLDS_RST: assert property (@(posedge clk) disable iff (!armed)
    (por_wait && !cond_ok) |=> sys_rst); // R8
  AST_CAUSE_ASSERTS: assert property (@(posedge clk) disable iff (!armed)
    rst_cause |=> sys_rst); // R9
  AST_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!armed)
    $rose(sys_rst) |-> $past(rst_cause)); // R9
  AST_HOLD_AFTER_LOW: assert property (@(posedge clk) disable iff (!armed)
    $rose(pin_hold) |-> ($past(!pin_sync) && pin_rst_en)); // R2
endmodule

bind rst_combiner rst_combiner_chk u_chk (
  .clk         (clk),
  .por_evt     (por_evt),
  .cond_ok     (cond_ok),
  .pin_rst_en  (pin_rst_en),
  .flag_wr_en  (flag_wr_en),
  .flag_wr_data(flag_wr_data),
  .pin_sync    (pin_sync),
  .pin_hold    (pin_hold),
  .por_wait    (por_wait),
  .rst_cause   (rst_cause),
  .sys_rst     (sys_rst),
  .por_flag    (por_flag)
);

// File: tb/sim_rst_combiner.sv
`timescale 1ns/1ps
module sim_rst_combiner;
  localparam int LOW = 8;
  localparam int REL = 16;

  logic clk = 1'b0;
  logic pin = 1'b1, en = 1'b1, por = 1'b1, cond = 1'b0, wr_en = 1'b0, wr_data = 1'b0;
  logic sys_rst, por_flag, pin_gpio;

  always #10 clk = ~clk;

  rst_combiner u0 (
    .clk(clk), .pin_n_raw(pin), .pin_rst_en(en), .por_evt(por), .cond_ok(cond),
    .flag_wr_en(wr_en), .flag_wr_data(wr_data),
    .sys_rst(sys_rst), .por_flag(por_flag), .pin_gpio(pin_gpio)
  );

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  // behavioural reference: pipeline delay, low run length, quiet run length
  bit m_s1, m_s2, m_wait, m_rst, m_flag, m_armed;
  int m_run, m_quiet;
  bit m_hold, m_cause;

  always @(posedge clk) begin
    m_hold  = en && (m_run >= LOW);
    m_cause = por || (m_wait && !cond) || m_hold;
    if (por) begin
      m_s1 = 1'b1; m_s2 = 1'b1; m_run = 0; m_armed = 1'b1;
    end else begin
      if (!en || m_s2) m_run = 0;
      else if (m_run < LOW) m_run++;
      m_s2 = m_s1;
      m_s1 = pin;
    end
    if (por) m_wait = 1'b1;
    else if (cond) m_wait = 1'b0;
    if (por) m_flag = 1'b0;
    else if (wr_en) m_flag = wr_data;
    if (m_cause) begin m_quiet = 0; m_rst = 1'b1; end
    else begin m_quiet++; if (m_quiet >= REL) m_rst = 1'b0; end
  end

  task automatic check(input string req, input string what, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (m_armed && !done) begin
      check("R1/R8/R9", "sys_rst model", sys_rst, m_rst);
      check("R5/R6/R7/R10", "por_flag model", por_flag, m_flag);
      check("R3/R4", "pin_gpio model", pin_gpio, en ? 1'b0 : m_s2);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      done = 1'b1;
      summary();
    end
  end

  initial begin
    step(3);
    check("R8", "reset state sys_rst", sys_rst, 1'b1);
    check("R5", "reset state flag", por_flag, 1'b0);
    por = 1'b0;
    step(30);
    check("R8", "held while cond low", sys_rst, 1'b1);
    cond = 1'b1;
    step(15);
    check("R9", "after 15 quiet edges", sys_rst, 1'b1);
    step(1);
    check("R9", "after 16 quiet edges", sys_rst, 1'b0);

    wr_en = 1'b1; wr_data = 1'b1; step(1); wr_en = 1'b0;
    check("R7", "flag set by write", por_flag, 1'b1);

    // short low pulse, then two short pulses split by one high sample
    pin = 1'b0; step(LOW - 1); pin = 1'b1;
    for (int i = 0; i < 20; i++) begin
      step(1);
      check("R2", "short pulse no reset", sys_rst, 1'b0);
    end
    pin = 1'b0; step(LOW - 1); pin = 1'b1; step(1); pin = 1'b0; step(LOW - 1); pin = 1'b1;
    for (int i = 0; i < 20; i++) begin
      step(1);
      check("R2", "restarted count no reset", sys_rst, 1'b0);
    end

    // qualified pin reset
    pin = 1'b0; step(30);
    check("R1", "pin held low resets", sys_rst, 1'b1);
    check("R6", "flag kept on pin reset", por_flag, 1'b1);
    pin = 1'b1; step(40);
    check("R9", "released after pin high", sys_rst, 1'b0);
    check("R6", "flag kept after release", por_flag, 1'b1);

    // pin as digital input
    en = 1'b0; pin = 1'b0;
    for (int i = 0; i < 30; i++) begin
      step(1);
      check("R4", "disabled pin no reset", sys_rst, 1'b0);
    end
    check("R4", "gpio shows low", pin_gpio, 1'b0);
    pin = 1'b1; step(1);
    check("R4", "gpio one edge later", pin_gpio, 1'b0);
    step(1);
    check("R4", "gpio two edges later", pin_gpio, 1'b1);

    // power-on with simultaneous write; pin still readable during reset
    por = 1'b1; cond = 1'b0; wr_en = 1'b1; wr_data = 1'b1; step(1);
    por = 1'b0; wr_en = 1'b0;
    check("R5", "por beats write", por_flag, 1'b0);
    pin = 1'b0; step(2);
    check("R3", "gpio follows pin under reset", pin_gpio, 1'b0);
    check("R3", "sys_rst held meanwhile", sys_rst, 1'b1);
    pin = 1'b1; step(2);
    check("R3", "gpio back high under reset", pin_gpio, 1'b1);
    en = 1'b1; step(1);
    check("R4", "gpio masked when enabled", pin_gpio, 1'b0);

    wr_en = 1'b1; wr_data = 1'b1; step(1);
    wr_data = 1'b0; step(1); wr_en = 1'b0;
    check("R10", "flag cleared by write", por_flag, 1'b0);
    wr_en = 1'b1; wr_data = 1'b1; step(1); wr_en = 1'b0;
    por = 1'b1; step(1); por = 1'b0;
    check("R5", "por clears flag", por_flag, 1'b0);
    cond = 1'b1; step(REL + 2);
    check("R9", "released again", sys_rst, 1'b0);

    done = 1'b1;
    summary();
  end
endmodule